// File: doc/BRIEF.md
# Burst Flash Read Interface

This block is the read side of a NOR-style flash device whose 16-bit bus carries both address and data. Here the shared bus is split into an inbound half (`ad_in`) and an outbound half (`dq_out` with its enable `dq_en`). The host pulls chip enable low and pulses the address-latch strobe to capture a start address. What follows depends on a 16-bit runtime configuration register. In asynchronous mode, the word at the latched address is driven once output enable has been low for a fixed number of clocks. In synchronous mode, the block waits a programmed number of clocks and then returns one word per clock at rising addresses. Those addresses either wrap inside an aligned block or run on until chip enable goes high.

A small computed cell array stands in for the flash cells. The configuration register is written and read back through a simple command port. The register returns to asynchronous mode on every reset, so burst reads need an explicit register write first. The burst style, the latency and the ready timing are all taken from the register at the moment the address is latched.

Configuration fields are bit 15 for mode (1 asynchronous, 0 synchronous burst), bits 13:11 for the wait code, bit 10 for early ready, and bit 4 for continuous burst (0 means wrapping). Bits 1:0 give the wrap length: 00 is 8 words, 01 is 16 words, and 10 or 11 is 32 words. All other bits are stored and read back unchanged.

Top module: `bflash_rd_if`

## Requirements
- R1: A synchronous reset sets the configuration register to 0x8000, clears `cfg_rvalid`, and leaves the block in asynchronous mode with `rdy` high and `dq_en` low.
- R2: A command with `cmd_valid`=1 and `cmd_wr`=1 loads `cmd_wdata` into the register at that edge. A command with `cmd_valid`=1 and `cmd_wr`=0 raises `cfg_rvalid` for one cycle after the edge, with `cfg_rdata` holding the register value.
- R3: In asynchronous mode, a latch edge (an edge with `ce_n`=0 and `adv_n`=0) captures the address and starts no burst. `rdy` stays high, and `dq_en` rises only after `oe_n` has been sampled low on T_OE consecutive edges, with the word at the latched address.
- R4: In synchronous mode with wait code n, `dq_en` stays low and `rdy` stays low, apart from the early case in R8, until the edge n+2 after the latch edge. The first word then appears.
- R5: After the first word, each further edge presents the next word of the burst sequence, one word per clock.
- R6: In wrapping burst, word i comes from address (S & ~(B-1)) | ((S+i) & (B-1)), where S is the start address and B is 8, 16 or 32 from the length code.
- R7: In continuous burst, word i comes from address (S+i) modulo the array depth, and the burst continues until `ce_n` is sampled high.
- R8: With bit 10 clear, `rdy` rises together with the first valid word. With bit 10 set, it rises one clock earlier. It then stays high for the whole burst.
- R9: A burst keeps the mode, latency, ready and wrap settings sampled at its latch edge, even if the register is written during the burst.
- R10: The cell word at address a is ((a*257) XOR 0xA5C3) modulo 2^16, and `dq_out` is zero whenever `dq_en` is low.
- R11: An edge with `ce_n` high ends any access: after it, `dq_en` is low and `rdy` is high.
- R12: During a synchronous burst with `oe_n` high, `dq_en` stays low while `rdy` keeps its normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Configuration command strobe |
| cmd_wr | input | 1 | 1 writes the register, 0 reads it |
| cmd_wdata | input | 16 | Value for a register write |
| cfg_rdata | output | 16 | Register value returned by a read command |
| cfg_rvalid | output | 1 | One-cycle flag for `cfg_rdata` |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address latch strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| ad_in | input | 16 | Inbound half of the shared bus (address) |
| dq_out | output | 16 | Outbound half of the shared bus (data) |
| dq_en | output | 1 | Drive enable for `dq_out` |
| rdy | output | 1 | Ready: high when data is, or is about to be, valid |

## Verification
The bench sweeps every wait code, both ready timings, all three wrap lengths and continuous mode. It uses start addresses near block edges and at the top of the array. An off-by-one in the latency counter would move the first word one clock early or late. A wrong wrap mask would carry into the next block instead of folding back. A continuous burst that ignored the array end would read past the top address. A register write in the middle of a burst is checked to leave that burst's timing alone. A reset after a switch to burst mode is checked to bring back asynchronous timing and the 0x8000 value, which catches a design that keeps the mode across reset.

// File: rtl/bflash_pkg.sv
`timescale 1ns/1ps
package bflash_pkg;
    localparam int          BUS_W    = 16;
    localparam logic [15:0] CFG_RST  = 16'h8000;
    localparam int          LAT_BASE = 2;

    typedef struct packed {
        logic       async_sel;
        logic [2:0] wait_code;
        logic       rdy_early;
        logic       cont;
        logic [1:0] wrap_len;
    } cfg_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ASYNC,
        RD_WAIT,
        RD_STREAM
    } rd_state_e;

    function automatic cfg_t cfg_unpack(input logic [15:0] r);
        cfg_t c;
        c.async_sel = r[15];
        c.wait_code = r[13:11];
        c.rdy_early = r[10];
        c.cont      = r[4];
        c.wrap_len  = r[1:0];
        return c;
    endfunction

    function automatic logic [15:0] cell_word(input logic [15:0] a);
        logic [31:0] p;
        p = ({16'd0, a} * 32'd257) ^ 32'h0000_A5C3;
        return p[15:0];
    endfunction
endpackage

// File: rtl/bflash_cfg_reg.sv
`timescale 1ns/1ps
module bflash_cfg_reg
    import bflash_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_wdata,
    output logic [15:0] cfg_q,
    output logic [15:0] rdata,
    output logic        rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RST;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            if (cmd_valid && cmd_wr)
                cfg_q <= cmd_wdata;
            rvalid <= cmd_valid && !cmd_wr;
            if (cmd_valid && !cmd_wr)
                rdata <= cfg_q;
        end
    end

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_wr) |=> (cfg_q == $past(cmd_wdata)));

    // R2
    cfg_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_wr) |=> (rvalid && rdata == $past(cfg_q)));
endmodule

// File: rtl/bflash_cell_rom.sv
`timescale 1ns/1ps
module bflash_cell_rom
    import bflash_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  word
);
    always_comb word = cell_word(16'(addr));
endmodule

// File: rtl/bflash_burst_seq.sv
`timescale 1ns/1ps
module bflash_burst_seq
    import bflash_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              latch,
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] addr_in,
    output rd_state_e         st,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              rdy_o
);
    localparam int LAT_W = 4;

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] offset_q;
    logic [LAT_W-1:0]  lat_left;
    cfg_t              bcfg;
    logic [ADDR_W-1:0] blk_mask;
    logic [ADDR_W-1:0] lin_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RD_IDLE;
            start_q  <= '0;
            offset_q <= '0;
            lat_left <= '0;
            bcfg     <= cfg_unpack(CFG_RST);
        end else if (ce_n) begin
            st <= RD_IDLE;
        end else if (latch) begin
            start_q  <= addr_in;
            offset_q <= '0;
            bcfg     <= cfg;
            if (cfg.async_sel) begin
                st <= RD_ASYNC;
            end else begin
                st       <= RD_WAIT;
                lat_left <= {1'b0, cfg.wait_code} + LAT_W'(LAT_BASE);
            end
        end else begin
            case (st)
                RD_WAIT: begin
                    lat_left <= lat_left - 1'b1;
                    if (lat_left == LAT_W'(1))
                        st <= RD_STREAM;
                end
                RD_STREAM: offset_q <= offset_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bcfg.wrap_len)
            2'b00:   blk_mask = ADDR_W'(7);
            2'b01:   blk_mask = ADDR_W'(15);
            default: blk_mask = ADDR_W'(31);
        endcase
        lin_sum = start_q + offset_q;
        if (st == RD_ASYNC)
            cur_addr = start_q;
        else if (bcfg.cont)
            cur_addr = lin_sum;
        else
            cur_addr = (start_q & ~blk_mask) | (lin_sum & blk_mask);
    end

    always_comb begin
        if (st == RD_WAIT)
            rdy_o = bcfg.rdy_early && (lat_left == LAT_W'(1));
        else
            rdy_o = 1'b1;
    end

    // R6
    wrap_block_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RD_STREAM && !bcfg.cont) |-> ((cur_addr & ~blk_mask) == (start_q & ~blk_mask)));

    // R7
    cont_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RD_STREAM && bcfg.cont && !ce_n && !latch)
        |=> (st == RD_STREAM && cur_addr == $past(cur_addr) + ADDR_W'(1)));

    // R11
    ce_end_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (st == RD_IDLE));
endmodule

// File: rtl/bflash_rd_if.sv
`timescale 1ns/1ps
module bflash_rd_if
    import bflash_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int T_OE   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_wdata,
    output logic [15:0] cfg_rdata,
    output logic        cfg_rvalid,
    input  logic        ce_n,
    input  logic        adv_n,
    input  logic        oe_n,
    input  logic [15:0] ad_in,
    output logic [15:0] dq_out,
    output logic        dq_en,
    output logic        rdy
);
    localparam int OEC_W = $clog2(T_OE + 1);

    logic [15:0]       cfg_q;
    cfg_t              cfg;
    logic              latch;
    rd_state_e         st;
    logic [ADDR_W-1:0] cur_addr;
    logic [BUS_W-1:0]  cell_q;
    logic [OEC_W-1:0]  oe_cnt;
    logic              async_ok;
    logic              sync_ok;

    bflash_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .cfg_q     (cfg_q),
        .rdata     (cfg_rdata),
        .rvalid    (cfg_rvalid)
    );

    always_comb cfg   = cfg_unpack(cfg_q);
    always_comb latch = !ce_n && !adv_n;

    bflash_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .latch    (latch),
        .cfg      (cfg),
        .addr_in  (ad_in[ADDR_W-1:0]),
        .st       (st),
        .cur_addr (cur_addr),
        .rdy_o    (rdy)
    );

    bflash_cell_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr (cur_addr),
        .word (cell_q)
    );

    always_ff @(posedge clk) begin
        if (rst || ce_n || oe_n)
            oe_cnt <= '0;
        else if (oe_cnt != OEC_W'(T_OE))
            oe_cnt <= oe_cnt + 1'b1;
    end

    always_comb begin
        async_ok = (st == RD_ASYNC) && (oe_cnt == OEC_W'(T_OE));
        sync_ok  = (st == RD_STREAM) && !oe_n;
        dq_en    = !ce_n && (async_ok || sync_ok);
        dq_out   = dq_en ? cell_q : '0;
    end

    // R4
    no_early_data_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RD_WAIT) |-> !dq_en);

    // R8
    rdy_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        dq_en |-> rdy);

    // R3
    async_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RD_ASYNC) |-> rdy);

    // R12
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_en);
endmodule

// File: tb/bflash_rd_if_test.sv
`timescale 1ns/1ps
module bflash_rd_if_test;
    localparam int ADDR_W = 8;
    localparam int T_OE   = 2;
    localparam int DEPTH  = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        ce_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] dq_out;
    logic        dq_en;
    logic        rdy;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bflash_rd_if #(.ADDR_W(ADDR_W), .T_OE(T_OE)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n), .ad_in(ad_in),
        .dq_out(dq_out), .dq_en(dq_en), .rdy(rdy)
    );

    function automatic logic [15:0] exp_word(input int a);
        int p;
        p = ((a * 257) ^ 32'hA5C3) & 32'hFFFF;
        return p[15:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_wr = 1'b0;
    endtask

    task automatic read_cfg_check(input string req, input logic [15:0] exp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_wr = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(req, {15'd0, cfg_rvalid}, 32'd1);
        check(req, {16'd0, cfg_rdata}, {16'd0, exp});
        @(negedge clk);
        check(req, {15'd0, cfg_rvalid}, 32'd0);
    endtask

    function automatic logic [15:0] mk_cfg(input int wc, input int early, input int cont, input int wl);
        logic [15:0] v;
        v = '0;
        v[13:11] = wc[2:0];
        v[10]    = early[0];
        v[4]     = cont[0];
        v[1:0]   = wl[1:0];
        return v;
    endfunction

    // synchronous burst: R4 R5 R6 R7 R8 R9 R10 R11 R12
    task automatic run_burst(input int start, input int wc, input int early, input int cont,
                             input int wl, input int nwords, input bit oe_hi, input bit mid_write);
        int lat;
        int blk;
        lat = wc + 2;
        blk = (wl == 0) ? 8 : (wl == 1) ? 16 : 32;
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; oe_n = oe_hi; ad_in = 16'(start);
        @(posedge clk);
        @(negedge clk);
        adv_n = 1'b1;
        if (mid_write) begin
            cmd_valid = 1'b1; cmd_wr = 1'b1;
            cmd_wdata = mk_cfg((wc + 3) % 8, 1 - early, 1 - cont, (wl + 1) % 3);
        end
        for (int j = 0; j < lat + nwords; j++) begin
            bit valid;
            int i;
            int a;
            logic [15:0] ew;
            valid = (j >= lat);
            i = j - lat;
            if (cont != 0) a = (start + i) % DEPTH;
            else a = (start & ~(blk - 1)) | ((start + i) & (blk - 1));
            ew = (valid && !oe_hi) ? exp_word(a) : 16'h0000;
            if (oe_hi) begin
                check("R12 dq_en gated by oe_n", {31'd0, dq_en}, 32'd0);
            end else if (!valid) begin
                check("R4 no data during latency", {31'd0, dq_en}, 32'd0);
            end else if (cont != 0) begin
                check("R7 continuous dq_en", {31'd0, dq_en}, 32'd1);
                check("R7 R10 continuous word", {16'd0, dq_out}, {16'd0, ew});
            end else begin
                check("R6 wrapping dq_en", {31'd0, dq_en}, 32'd1);
                check("R5 R6 R10 wrapping word", {16'd0, dq_out}, {16'd0, ew});
            end
            check(mid_write ? "R9 rdy timing kept" : "R8 rdy timing",
                  {31'd0, rdy}, {31'd0, valid || (early != 0 && j == lat - 1)});
            @(posedge clk);
            @(negedge clk);
            cmd_valid = 1'b0; cmd_wr = 1'b0;
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 ce_n ends burst dq_en", {31'd0, dq_en}, 32'd0);
        check("R11 ce_n ends burst rdy", {31'd0, rdy}, 32'd1);
    endtask

    // asynchronous access: R3 R10
    task automatic run_async(input string req, input int a);
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1; ad_in = 16'(a);
        @(posedge clk);
        @(negedge clk);
        adv_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            check(req, {31'd0, dq_en}, 32'd0);
            check(req, {31'd0, rdy}, 32'd1);
            @(posedge clk);
            @(negedge clk);
        end
        oe_n = 1'b0;
        for (int k = 1; k <= T_OE; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(req, {31'd0, dq_en}, {31'd0, k == T_OE});
            check(req, {16'd0, dq_out}, (k == T_OE) ? {16'd0, exp_word(a)} : 32'd0);
            check(req, {31'd0, rdy}, 32'd1);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 async end", {31'd0, dq_en}, 32'd0);
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int starts[4];
        starts[0] = 0; starts[1] = 5; starts[2] = 61; starts[3] = 254;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 dq_en after reset", {31'd0, dq_en}, 32'd0);
        check("R1 rdy after reset", {31'd0, rdy}, 32'd1);
        check("R1 cfg_rvalid after reset", {31'd0, cfg_rvalid}, 32'd0);
        read_cfg_check("R1 R2 reset cfg value", 16'h8000);

        // R3 default mode is asynchronous
        run_async("R1 R3 async after reset", 16'h2C);
        run_async("R3 async access", 255);

        // R2 write and read back
        write_cfg(16'h5A3C);
        read_cfg_check("R2 readback", 16'h5A3C);

        // sweep of synchronous bursts
        for (int wc = 0; wc < 8; wc++)
            for (int early = 0; early < 2; early++)
                for (int m = 0; m < 4; m++)
                    for (int s = 0; s < 4; s++) begin
                        int cont;
                        int wl;
                        cont = (m == 3) ? 1 : 0;
                        wl = (m == 3) ? 0 : m;
                        write_cfg(mk_cfg(wc, early, cont, wl));
                        run_burst(starts[s], wc, early, cont, wl, 40, 1'b0, 1'b0);
                    end

        // length code 11 behaves as 32 words (R6)
        write_cfg(mk_cfg(1, 0, 0, 3));
        run_burst(45, 1, 0, 0, 2, 40, 1'b0, 1'b0);

        // R9 mid-burst write
        write_cfg(mk_cfg(2, 0, 0, 0));
        run_burst(13, 2, 0, 0, 0, 20, 1'b0, 1'b1);
        write_cfg(mk_cfg(6, 1, 1, 1));
        run_burst(250, 6, 1, 1, 1, 20, 1'b0, 1'b1);

        // R12 oe_n held high
        write_cfg(mk_cfg(3, 1, 0, 1));
        run_burst(7, 3, 1, 0, 1, 12, 1'b1, 1'b0);

        // R1 reset returns to asynchronous mode
        write_cfg(mk_cfg(0, 0, 1, 0));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_cfg_check("R1 cfg after second reset", 16'h8000);
        run_async("R1 R3 async after second reset", 99);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule